// File: doc/BRIEF.md
# Upper-Group DMA Channel Control Registers

This block holds the write-side control state for the upper four channels of a legacy DMA controller. Channel index 0 of the block is the group's first channel (channel 4). A simple byte-wide I/O write bus reaches the block, and it decodes six even port offsets. Three of those ports carry data: the software request port, the single-channel mask port and the mode port. The other three are data-less commands: clear the byte-pointer flip-flop, master clear, and clear all masks.

For every channel the block keeps a mask bit, a software request bit and a six-bit mode field. It also keeps one byte-pointer flip-flop. A neighbouring address/count block flips this flip-flop through a toggle input. All stored state appears on the outputs. Two one-cycle event flags mark a request write whose channel select is zero, and a mode write that uses the reserved transfer type. A level flag reports a configuration error when the first channel is unmasked but not in cascade mode. Only the first channel takes part in transfers. The block still accepts writes for the other three and stores them.

Top module: `dma_hi_ctrl`

## Requirements
- R1: After reset, all four mask bits are 1. All requests are 0. Every mode field is 0. The byte pointer, both event flags and the configuration-error flag are 0.
- R2: A write to offset D2h with select bits [1:0] equal to 01, 10 or 11 updates that channel's request bit (index 1, 2 or 3) to the value of bit 2.
- R3: A write to D2h with select 00 changes no request bit. It raises illegal_req_o for exactly the following cycle.
- R4: A write to D4h sets the mask bit of channel index [1:0] (00 to 11) to the value of bit 2.
- R5: A write to D6h stores bits [7:2] into the mode of channel index [1:0] and leaves the other channels' modes unchanged. The fields are: [7:6] transfer mode (00 demand, 01 single, 10 block, 11 cascade), [5] decrement, [4] auto-initialize, and [3:2] type (00 verify, 01 to memory, 10 from memory, 11 reserved).
- R6: A mode write with type 11 is stored, and rsvd_type_o is raised for exactly the following cycle.
- R7: A pulse on bp_toggle inverts the byte pointer. A write of any value to D8h clears it, and the clear wins over a toggle in the same cycle.
- R8: A write to DAh returns all state to the R1 values.
- R9: A write to DCh clears all four mask bits and leaves requests, modes and the pointer unchanged.
- R10: cfg_err_o is 1 exactly when channel index 0 is unmasked and its transfer mode is not cascade (11).
- R11: Writes to any other offset, and cycles with wr_en low, change no state.
- R12: Bits [7:3] of request and mask writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Port offset |
| wr_data | input | 8 | Write data |
| bp_toggle | input | 1 | Flip the byte pointer (from the address/count side) |
| mask_o | output | 4 | Mask bit per channel |
| req_o | output | 4 | Software request bit per channel |
| xfer_mode_o | output | 8 | Transfer mode, 2 bits per channel |
| addr_dec_o | output | 4 | Address-decrement bit per channel |
| auto_init_o | output | 4 | Auto-initialize bit per channel |
| xfer_type_o | output | 8 | Transfer type, 2 bits per channel |
| byte_ptr_o | output | 1 | Byte-pointer flip-flop |
| illegal_req_o | output | 1 | One-cycle flag for a request write with select 00 |
| rsvd_type_o | output | 1 | One-cycle flag for a mode write of reserved type |
| cfg_err_o | output | 1 | First channel unmasked while not in cascade |

## Verification
Every result of a write or toggle is due in the cycle right after the edge that captures it. This covers the stored state, the derived configuration-error level and the two event flags. The bench drives on the falling edge and pushes the expected output picture, tagged with the cycle it is due. The monitor compares on the next falling edge. Idle cycles also push expectations, which checks that the event flags fall again after one cycle.

// File: rtl/dma_hi_pkg.sv
package dma_hi_pkg;

  localparam int NCH  = 4;
  localparam int SELW = $clog2(NCH);

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    XT_VERIFY   = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_RSVD     = 2'b11
  } xfer_type_e;

  // Field order matches write data bits [7:2]
  typedef struct packed {
    xfer_mode_e mode;
    logic       dec;
    logic       auto_init;
    xfer_type_e ttype;
  } chan_mode_t;

  typedef struct packed {
    logic req_wr;
    logic mask_wr;
    logic mode_wr;
    logic bp_clr;
    logic mclr;
    logic mask_all_clr;
  } cmd_t;

  function automatic logic [SELW-1:0] field_sel(input logic [7:0] d);
    return d[SELW-1:0];
  endfunction

  function automatic logic field_level(input logic [7:0] d);
    return d[2];
  endfunction

  function automatic chan_mode_t field_mode(input logic [7:0] d);
    return chan_mode_t'(d[7:2]);
  endfunction

endpackage

// File: rtl/dma_hi_decode.sv
module dma_hi_decode
  import dma_hi_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  OFS_REQ  = 8'hD2,
  parameter logic [7:0]  OFS_MASK = 8'hD4,
  parameter logic [7:0]  OFS_MODE = 8'hD6,
  parameter logic [7:0]  OFS_BPC  = 8'hD8,
  parameter logic [7:0]  OFS_MCLR = 8'hDA,
  parameter logic [7:0]  OFS_MALL = 8'hDC
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output cmd_t              cmd
);

  always_comb begin
    cmd = '0;
    if (wr_en) begin
      cmd.req_wr       = (wr_addr == ADDR_W'(OFS_REQ));
      cmd.mask_wr      = (wr_addr == ADDR_W'(OFS_MASK));
      cmd.mode_wr      = (wr_addr == ADDR_W'(OFS_MODE));
      cmd.bp_clr       = (wr_addr == ADDR_W'(OFS_BPC));
      cmd.mclr         = (wr_addr == ADDR_W'(OFS_MCLR));
      cmd.mask_all_clr = (wr_addr == ADDR_W'(OFS_MALL));
    end
  end

  // R11: at most one command per write, none while idle
  always_comb begin
    assert_cmd_single_R11: assert ($onehot0(cmd));
  end

endmodule

// File: rtl/dma_hi_chan.sv
module dma_hi_chan
  import dma_hi_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_t       cmd,
  input  logic [7:0] wr_data,
  output logic       mask_o,
  output logic       req_o,
  output chan_mode_t mode_o
);

  localparam logic [SELW-1:0] MY_SEL = SELW'(IDX);
  localparam logic            REQ_OK = (IDX != 0);

  logic hit;
  logic zero_sel;
  assign hit      = (field_sel(wr_data) == MY_SEL);
  assign zero_sel = (field_sel(wr_data) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || cmd.mclr) begin
      mask_o <= 1'b1;
      req_o  <= 1'b0;
      mode_o <= '0;
    end else begin
      if (cmd.mask_all_clr)
        mask_o <= 1'b0;
      else if (cmd.mask_wr && hit)
        mask_o <= field_level(wr_data);
      if (REQ_OK && cmd.req_wr && hit)
        req_o <= field_level(wr_data);
      if (cmd.mode_wr && hit)
        mode_o <= field_mode(wr_data);
    end
  end

  assert_mclr_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.mclr |=> (mask_o && !req_o && mode_o == '0));

  assert_mask_all_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.mask_all_clr |=> !mask_o);

  assert_mode_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.mode_wr && !hit) |=> $stable(mode_o));

  assert_req_zero_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.req_wr && zero_sel) |=> $stable(req_o));

endmodule

// File: rtl/dma_hi_bptr.sv
module dma_hi_bptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic toggle,
  output logic bp_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) bp_o <= 1'b0;
    else if (toggle)   bp_o <= ~bp_o;
  end

  assert_bp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !bp_o);

  assert_bp_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clr) |=> (bp_o != $past(bp_o)));

endmodule

// File: rtl/dma_hi_ctrl.sv
module dma_hi_ctrl
  import dma_hi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              bp_toggle,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [2*NCH-1:0]  xfer_mode_o,
  output logic [NCH-1:0]    addr_dec_o,
  output logic [NCH-1:0]    auto_init_o,
  output logic [2*NCH-1:0]  xfer_type_o,
  output logic              byte_ptr_o,
  output logic              illegal_req_o,
  output logic              rsvd_type_o,
  output logic              cfg_err_o
);

  cmd_t       cmd;
  chan_mode_t mode_q [NCH];

  // Named internal events
  logic illegal_evt;
  logic rsvd_evt;
  logic cascade_wr_ch0;
  logic bp_clr_any;

  dma_hi_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dma_hi_chan #(.IDX(i)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .wr_data (wr_data),
      .mask_o  (mask_o[i]),
      .req_o   (req_o[i]),
      .mode_o  (mode_q[i])
    );
    assign xfer_mode_o[2*i +: 2] = mode_q[i].mode;
    assign addr_dec_o[i]         = mode_q[i].dec;
    assign auto_init_o[i]        = mode_q[i].auto_init;
    assign xfer_type_o[2*i +: 2] = mode_q[i].ttype;
  end

  assign bp_clr_any = cmd.bp_clr | cmd.mclr;

  dma_hi_bptr u_bptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (bp_clr_any),
    .toggle (bp_toggle),
    .bp_o   (byte_ptr_o)
  );

  assign illegal_evt    = cmd.req_wr && (field_sel(wr_data) == '0);
  assign rsvd_evt       = cmd.mode_wr && (field_mode(wr_data).ttype == XT_RSVD);
  assign cascade_wr_ch0 = cmd.mode_wr && (field_sel(wr_data) == '0)
                          && (field_mode(wr_data).mode == XM_CASCADE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_req_o <= 1'b0;
      rsvd_type_o   <= 1'b0;
    end else begin
      illegal_req_o <= illegal_evt;
      rsvd_type_o   <= rsvd_evt;
    end
  end

  assign cfg_err_o = !mask_o[0] && (mode_q[0].mode != XM_CASCADE);

  assert_illegal_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |=> (illegal_req_o && $stable(req_o)));

  assert_rsvd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_evt |=> rsvd_type_o);

  assert_cascade_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_wr_ch0 |=> !cfg_err_o);

  assert_req_ch4_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o[0]);

endmodule

// File: tb/dma_hi_ctrl_tb.sv
module dma_hi_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bp_toggle = 1'b0;
  logic [3:0] mask_o, req_o, addr_dec_o, auto_init_o;
  logic [7:0] xfer_mode_o, xfer_type_o;
  logic       byte_ptr_o, illegal_req_o, rsvd_type_o, cfg_err_o;

  always #10 clk = ~clk;

  dma_hi_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bp_toggle(bp_toggle), .mask_o(mask_o),
    .req_o(req_o), .xfer_mode_o(xfer_mode_o), .addr_dec_o(addr_dec_o),
    .auto_init_o(auto_init_o), .xfer_type_o(xfer_type_o),
    .byte_ptr_o(byte_ptr_o), .illegal_req_o(illegal_req_o),
    .rsvd_type_o(rsvd_type_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic [31:0] due;
    logic [7:0]  rq;
    logic [3:0]  mask;
    logic [3:0]  req;
    logic [7:0]  xm;
    logic [3:0]  dec;
    logic [3:0]  ai;
    logic [7:0]  xt;
    logic        bp;
    logic        ill;
    logic        rsv;
    logic        cfg;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Bench reference state
  logic [3:0] m_mask = 4'hF, m_req = '0, m_dec = '0, m_ai = '0;
  logic [7:0] m_xm = '0, m_xt = '0;
  logic       m_bp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_reset();
    m_mask = 4'hF; m_req = '0; m_dec = '0; m_ai = '0;
    m_xm = '0; m_xt = '0; m_bp = 1'b0;
  endtask

  task automatic push(input int rq, input logic ill, input logic rsv);
    exp_t e;
    e.due = cyc + 1; e.rq = 8'(rq);
    e.mask = m_mask; e.req = m_req; e.xm = m_xm; e.dec = m_dec;
    e.ai = m_ai; e.xt = m_xt; e.bp = m_bp; e.ill = ill; e.rsv = rsv;
    e.cfg = !m_mask[0] && (m_xm[1:0] != 2'b11);
    q.push_back(e);
  endtask

  // Driver: one bus cycle, reference update, expectation pushed
  task automatic cyc_drive(input logic en, input logic [7:0] a,
                           input logic [7:0] d, input logic tog, input int rq);
    logic ill, rsv;
    int   ch;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; bp_toggle = tog;
    ill = 1'b0; rsv = 1'b0;
    ch = int'(d[1:0]);
    if (tog) m_bp = ~m_bp;
    if (en) begin
      case (a)
        8'hD2: if (ch == 0) ill = 1'b1; else m_req[ch] = d[2];
        8'hD4: m_mask[ch] = d[2];
        8'hD6: begin
          m_xm[2*ch +: 2] = d[7:6]; m_dec[ch] = d[5];
          m_ai[ch] = d[4]; m_xt[2*ch +: 2] = d[3:2];
          rsv = (d[3:2] == 2'b11);
        end
        8'hD8: m_bp = 1'b0;
        8'hDA: model_reset();
        8'hDC: m_mask = 4'h0;
        default: ;
      endcase
    end
    push(rq, ill, rsv);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int rq);
    cyc_drive(1'b1, a, d, 1'b0, rq);
  endtask

  task automatic idle(input int rq);
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b0, rq);
  endtask

  // Monitor: compare when each expectation falls due
  always @(negedge clk) begin
    while (q.size() > 0 && int'(q[0].due) == cyc) begin
      exp_t e;
      exp_t a;
      e = q.pop_front();
      a = e;
      a.mask = mask_o; a.req = req_o; a.xm = xfer_mode_o; a.dec = addr_dec_o;
      a.ai = auto_init_o; a.xt = xfer_type_o; a.bp = byte_ptr_o;
      a.ill = illegal_req_o; a.rsv = rsvd_type_o; a.cfg = cfg_err_o;
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL R%0d cycle %0d actual %h expected %h", e.rq, cyc, a, e);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);                       // R1 reset picture
    wr(8'hD6, 8'hC0, 5);           // R5 ch4 cascade
    wr(8'hD4, 8'h00, 4);           // R4 unmask ch4
    wr(8'hD6, 8'h00, 10);          // R10 ch4 demand while unmasked
    wr(8'hD6, 8'h80, 10);          // R10 block still errors
    wr(8'hD6, 8'hC0, 10);          // R10 cascade clears error
    wr(8'hD2, 8'h05, 2);           // R2 set ch5
    wr(8'hD2, 8'h07, 2);           // R2 set ch7
    wr(8'hD2, 8'h03, 2);           // R2 clear ch7
    wr(8'hD2, 8'h04, 3);           // R3 illegal select
    idle(3);                       // R3 flag lasts one cycle
    wr(8'hD2, 8'h00, 3);           // R3 illegal clear attempt
    wr(8'hD4, 8'h01, 4);           // R4 unmask ch5
    wr(8'hD4, 8'hFA, 12);          // R12 reserved bits, unmask ch6
    wr(8'hD2, 8'hF9, 12);          // R12 reserved bits, clear ch5
    wr(8'hD6, 8'h3D, 6);           // R6 reserved type on ch5
    idle(6);
    wr(8'hD6, 8'h6A, 5);           // R5 ch6 single/dec/from-mem
    wr(8'hD6, 8'hB3, 5);           // R5 ch7 block/auto/verify
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b1, 7);   // R7 toggle
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b1, 7);
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b1, 7);
    cyc_drive(1'b1, 8'hD8, 8'h5A, 1'b1, 7);   // R7 clear beats toggle
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b1, 7);
    wr(8'hD8, 8'hFF, 7);
    wr(8'hD3, 8'hFF, 11);          // R11 odd offset ignored
    wr(8'hDE, 8'hFF, 11);          // R11 unused offset
    cyc_drive(1'b0, 8'hDA, 8'h00, 1'b0, 11);  // R11 no strobe
    wr(8'hD2, 8'h06, 2);           // R2 set ch6
    wr(8'hDC, 8'h00, 9);           // R9 clear all masks
    wr(8'hD4, 8'h04, 4);           // R4 mask ch4 again
    cyc_drive(1'b0, 8'h00, 8'h00, 1'b1, 7);
    wr(8'hDA, 8'h00, 8);           // R8 master clear
    idle(8);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule